// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

One DMA channel. It takes its work from control blocks held in memory. Software writes the address of the first block into the channel's register window and sets the run bit. The channel then reads the block's header and moves the described number of bytes, one 32-bit word at a time, over a request/acknowledge memory port. When the block is done, the channel follows the block's link word to the next block. A link of zero stops the channel.

Each block carries its own transfer-info word. This word sets whether the source and destination addresses step or stay fixed, whether a side reads zeros or drops its writes, and whether reads or writes are paced by one of several peripheral data-request lines. It can also insert idle cycles before every word and ask for an interrupt when the block ends. One control/status register starts and pauses the channel and holds the end and interrupt flags, which are cleared by writing 1. The same register also carries the self-clearing abort and reset commands.

Top module: `dmac_chan`

## Requirements
- R1: After reset, control/status (offset 0x00) reads 0x0000_0010 (only the paused-or-idle bit 4 set), `irq` is low and `mem_req` is low.
- R2: The block address register (0x04) accepts a write only while the channel is idle. After it is written and bit 0 (run) of 0x00 is set, the channel reads six words from the block address: info at +0x00, source at +0x04, destination at +0x08, byte length at +0x0C, stride at +0x10 and link at +0x14. These values read back at 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C.
- R3: The byte length is rounded down to a multiple of 4, and each word is read from the source and written to the destination. Info bit 8 adds 4 to the source after every word and info bit 4 adds 4 to the destination; without these bits the address stays fixed. A length of 0 ends the block with no data access. A request is held with a stable address until it is acknowledged.
- R4: At the end of each block, bit 1 (end) of 0x00 is set and 0x04 takes the link value. If the link is nonzero, that block is run next. If it is zero, bit 0 clears. Bit 2 (interrupt) is set at block end only when info bit 0 is set, and `irq` follows bit 2.
- R5: Writing 1 to bit 1 or bit 2 of 0x00 clears that flag. Writing 0 to these bits leaves them unchanged.
- R6: Info bit 11 makes every read return zero with no read access. Info bit 7 suppresses every destination write.
- R7: Info bit 10 delays each read, and info bit 6 each write, until the data-request line chosen by info bits 20:16 is high. While the channel waits, bit 5 of 0x00 reads 1.
- R8: Info bits 25:21 give a count W of idle cycles inserted before every word, so a block of n words takes n*W cycles longer than with W=0.
- R9: Writing 0 to bit 0 pauses the channel. An access already in flight completes, no new access starts, and bit 4 reads 1. Writing 1 again resumes the transfer where it stopped.
- R10: Writing 1 to bit 30 of 0x00 ends the current block early. The end flag is set and the channel continues with the link pointer.
- R11: Writing 1 to bit 31 of 0x00 returns the channel to idle at once, with bits 0, 1 and 2 clear and no further memory request.
- R12: Debug register 0x20 bit 28 reads 1 in the reduced variant (parameter LITE=1). That variant caps a block at 65532 bytes; the full variant caps it at 2^30 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| dreq | input | NDREQ | Peripheral data-request lines |
| irq | output | 1 | Interrupt, high while the interrupt flag is set |

## Verification
A wrong fetch index or a misplaced header word shows up directly in the header read-back registers. It also shows as destination words landing in the wrong place once the block finishes. A bad address-step or ignore decision corrupts destination memory word for word, so the bench can point to the exact word index. A run, pause or pacing state that is stuck shows within a few tens of cycles: the remaining-length register stops moving, or the channel never returns to idle. Errors in the wait-cycle count show as an exact difference in the measured run time between two runs.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_FETCH, S_SETUP, S_GAP, S_SRC, S_RD, S_DST, S_WR, S_DONE
    } dmac_st_e;

    // Register window offsets (bytes)
    localparam logic [5:0] OFF_CS   = 6'h00;
    localparam logic [5:0] OFF_CBA  = 6'h04;
    localparam logic [5:0] OFF_TI   = 6'h08;
    localparam logic [5:0] OFF_SRC  = 6'h0C;
    localparam logic [5:0] OFF_DST  = 6'h10;
    localparam logic [5:0] OFF_LEN  = 6'h14;
    localparam logic [5:0] OFF_STRD = 6'h18;
    localparam logic [5:0] OFF_NXT  = 6'h1C;
    localparam logic [5:0] OFF_DBG  = 6'h20;

    // Control/status bit positions
    localparam int CS_RUN   = 0;
    localparam int CS_END   = 1;
    localparam int CS_INT   = 2;
    localparam int CS_DRQ   = 3;
    localparam int CS_PAUSE = 4;
    localparam int CS_HELD  = 5;
    localparam int CS_WWAIT = 6;
    localparam int CS_ABORT = 30;
    localparam int CS_RESET = 31;

    // Transfer-info bit positions
    localparam int TI_INTEN = 0;
    localparam int TI_DINC  = 4;
    localparam int TI_DPACE = 6;
    localparam int TI_DIGN  = 7;
    localparam int TI_SINC  = 8;
    localparam int TI_SPACE = 10;
    localparam int TI_SIGN  = 11;
    localparam int TI_SEL_LO  = 16;
    localparam int TI_WAIT_LO = 21;
    localparam int SELW  = 5;
    localparam int WAITW = 5;

    localparam int DBG_LITE = 28;

    // Header words actually fetched (padding words are skipped)
    localparam int HDR_WORDS = 6;

endpackage

// File: rtl/dmac_dreq_sel.sv
module dmac_dreq_sel #(
    parameter int NDREQ = 4,
    parameter int SELW  = 5
) (
    input  logic [NDREQ-1:0] lines,
    input  logic [SELW-1:0]  sel,
    output logic             lvl
);
    localparam int IW = (NDREQ > 1) ? $clog2(NDREQ) : 1;

    always_comb begin
        if (int'(sel) < NDREQ) lvl = lines[sel[IW-1:0]];
        else                   lvl = 1'b0;
    end
endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
    import dmac_pkg::*;
#(
    parameter bit LITE = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [5:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    input  logic        dreq_lvl,
    output logic        run_o,
    output logic        end_o,
    output logic        int_o,
    output logic        paused_o,
    output logic        held_o,
    output logic        wwait_o,
    output logic [31:0] cba_o,
    output logic [31:0] ti_o,
    output logic [31:0] src_o,
    output logic [31:0] dst_o,
    output logic [31:0] len_o,
    output logic [31:0] strd_o,
    output logic [31:0] nxt_o
);
    localparam logic [31:0] LEN_CAP = LITE ? 32'd65532 : 32'h4000_0000;
    localparam int IDXW = $clog2(HDR_WORDS);

    typedef struct packed {
        dmac_st_e          st;
        logic              run;
        logic              endf;
        logic              intf;
        logic              busy;
        logic              abort_p;
        logic [IDXW-1:0]   idx;
        logic [WAITW-1:0]  gap;
        logic [31:0]       cba;
        logic [31:0]       ti;
        logic [31:0]       src;
        logic [31:0]       dst;
        logic [31:0]       len;
        logic [31:0]       strd;
        logic [31:0]       nxt;
        logic [31:0]       data;
    } eng_s;

    eng_s q, d;
    logic wr_cs, wr_cba, cmd_reset, grant, step, pace_ok;

    function automatic logic [31:0] cap_len(input logic [31:0] l);
        logic [31:0] a;
        a = {l[31:2], 2'b00};
        return (a > LEN_CAP) ? LEN_CAP : a;
    endfunction

    assign wr_cs     = reg_we && (reg_addr == OFF_CS);
    assign wr_cba    = reg_we && (reg_addr == OFF_CBA);
    assign cmd_reset = wr_cs && reg_wdata[CS_RESET];
    assign pace_ok   = dreq_lvl;

    always_comb begin
        d         = q;
        grant     = q.run | q.busy;
        step      = 1'b0;
        held_o    = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.cba + 32'({q.idx, 2'b00});
        mem_wdata = q.data;

        if (wr_cs) begin
            d.run = reg_wdata[CS_RUN];
            if (reg_wdata[CS_END]) d.endf = 1'b0;
            if (reg_wdata[CS_INT]) d.intf = 1'b0;
            if (reg_wdata[CS_ABORT] && q.st != S_IDLE) d.abort_p = 1'b1;
        end
        if (wr_cba && q.st == S_IDLE) d.cba = reg_wdata;

        unique case (q.st)
            S_IDLE: begin
                d.abort_p = 1'b0;
                if (q.run) begin
                    d.st  = S_FETCH;
                    d.idx = '0;
                end
            end
            S_FETCH: begin
                mem_req = grant;
                if (mem_req && mem_ack) begin
                    case (q.idx)
                        0:       d.ti   = mem_rdata;
                        1:       d.src  = mem_rdata;
                        2:       d.dst  = mem_rdata;
                        3:       d.len  = mem_rdata;
                        4:       d.strd = mem_rdata;
                        default: d.nxt  = mem_rdata;
                    endcase
                    if (int'(q.idx) == HDR_WORDS - 1) d.st = S_SETUP;
                    else                              d.idx = q.idx + 1'b1;
                end
            end
            S_SETUP: begin
                if (q.abort_p) d.st = S_DONE;
                else if (q.run) begin
                    d.len = cap_len(q.len);
                    d.gap = q.ti[TI_WAIT_LO +: WAITW];
                    d.st  = (cap_len(q.len) == 32'd0) ? S_DONE : S_GAP;
                end
            end
            S_GAP: begin
                if (q.abort_p) d.st = S_DONE;
                else if (q.run) begin
                    if (q.gap != '0) d.gap = q.gap - 1'b1;
                    else             d.st  = S_SRC;
                end
            end
            S_SRC: begin
                if (q.abort_p) d.st = S_DONE;
                else if (q.ti[TI_SPACE] && !pace_ok) held_o = 1'b1;
                else if (q.run) begin
                    if (q.ti[TI_SIGN]) begin
                        d.data = 32'd0;
                        d.st   = S_DST;
                    end else begin
                        d.st   = S_RD;
                    end
                end
            end
            S_RD: begin
                mem_req  = grant;
                mem_addr = q.src;
                if (mem_req && mem_ack) begin
                    d.data = mem_rdata;
                    d.st   = S_DST;
                end
            end
            S_DST: begin
                if (q.abort_p) d.st = S_DONE;
                else if (q.ti[TI_DPACE] && !pace_ok) held_o = 1'b1;
                else if (q.run) begin
                    if (q.ti[TI_DIGN]) step = 1'b1;
                    else               d.st = S_WR;
                end
            end
            S_WR: begin
                mem_req  = grant;
                mem_we   = 1'b1;
                mem_addr = q.dst;
                if (mem_req && mem_ack) step = 1'b1;
            end
            S_DONE: begin
                d.endf    = 1'b1;
                if (q.ti[TI_INTEN]) d.intf = 1'b1;
                d.abort_p = 1'b0;
                d.cba     = q.nxt;
                d.idx     = '0;
                if (q.nxt == 32'd0) begin
                    d.run = 1'b0;
                    d.st  = S_IDLE;
                end else begin
                    d.st  = S_FETCH;
                end
            end
            default: d.st = S_IDLE;
        endcase

        if (step) begin
            if (q.ti[TI_SINC]) d.src = q.src + 32'd4;
            if (q.ti[TI_DINC]) d.dst = q.dst + 32'd4;
            d.len = q.len - 32'd4;
            if (q.len == 32'd4) d.st = S_DONE;
            else begin
                d.st  = S_GAP;
                d.gap = q.ti[TI_WAIT_LO +: WAITW];
            end
        end

        d.busy = mem_req & ~mem_ack;

        if (cmd_reset) begin
            d.st      = S_IDLE;
            d.run     = 1'b0;
            d.endf    = 1'b0;
            d.intf    = 1'b0;
            d.busy    = 1'b0;
            d.abort_p = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign run_o    = q.run;
    assign end_o    = q.endf;
    assign int_o    = q.intf;
    assign paused_o = ~q.run & ~q.busy;
    assign wwait_o  = (q.st == S_WR) && q.busy;
    assign cba_o    = q.cba;
    assign ti_o     = q.ti;
    assign src_o    = q.src;
    assign dst_o    = q.dst;
    assign len_o    = q.len;
    assign strd_o   = q.strd;
    assign nxt_o    = q.nxt;

    // R3: an outstanding request keeps its address and direction
    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !cmd_reset) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R3: the word loop only runs with a nonzero, word-aligned remainder
    a_r3_len_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_GAP || q.st == S_SRC || q.st == S_DST) |-> (q.len[1:0] == 2'b00 && q.len != 32'd0));

    // R6: no write access while the block ignores destination writes
    a_r6_no_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !q.ti[TI_DIGN]);

    // R7: a paced write is only issued after the request line was seen high
    a_r7_paced_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !q.busy && q.ti[TI_DPACE]) |-> $past(dreq_lvl));

    // R4: the interrupt flag only rises for a block that asked for it
    a_r4_int_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.intf) |-> q.ti[TI_INTEN]);

    // R11: the reset command leaves the channel stopped and quiet
    a_r11_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> (!mem_req && !q.run && !q.intf));

endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
#(
    parameter bit LITE  = 1'b0,
    parameter int NDREQ = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [5:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    input  logic [NDREQ-1:0] dreq,
    output logic             irq
);
    logic        dreq_lvl, run, endf, intf, paused, held, wwait;
    logic [31:0] cba, ti, src, dst, len, strd, nxt, cs, dbg;

    dmac_dreq_sel #(.NDREQ(NDREQ), .SELW(SELW)) i_sel (
        .lines (dreq),
        .sel   (ti[TI_SEL_LO +: SELW]),
        .lvl   (dreq_lvl)
    );

    dmac_engine #(.LITE(LITE)) i_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .dreq_lvl  (dreq_lvl),
        .run_o     (run),
        .end_o     (endf),
        .int_o     (intf),
        .paused_o  (paused),
        .held_o    (held),
        .wwait_o   (wwait),
        .cba_o     (cba),
        .ti_o      (ti),
        .src_o     (src),
        .dst_o     (dst),
        .len_o     (len),
        .strd_o    (strd),
        .nxt_o     (nxt)
    );

    always_comb begin
        cs            = '0;
        cs[CS_RUN]    = run;
        cs[CS_END]    = endf;
        cs[CS_INT]    = intf;
        cs[CS_DRQ]    = dreq_lvl;
        cs[CS_PAUSE]  = paused;
        cs[CS_HELD]   = held;
        cs[CS_WWAIT]  = wwait;
        dbg           = '0;
        dbg[DBG_LITE] = LITE;
        unique case (reg_addr)
            OFF_CS:   reg_rdata = cs;
            OFF_CBA:  reg_rdata = cba;
            OFF_TI:   reg_rdata = ti;
            OFF_SRC:  reg_rdata = src;
            OFF_DST:  reg_rdata = dst;
            OFF_LEN:  reg_rdata = len;
            OFF_STRD: reg_rdata = strd;
            OFF_NXT:  reg_rdata = nxt;
            OFF_DBG:  reg_rdata = dbg;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = intf;

    // R1: the interrupt pin mirrors the flag that software clears
    a_r1_irq_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFF_CS && reg_wdata[CS_INT]) |=> (!irq || run));

endmodule

// File: tb/test_dmac_chan.sv
`timescale 1ns/1ps
module tb_mem (
    input  logic        clk,
    input  logic        req,
    input  logic        we,
    input  logic [31:0] addr,
    input  logic [31:0] wdata,
    output logic        ack,
    output logic [31:0] rdata
);
    logic [31:0] mem [0:1023];
    int wr_count;

    initial begin
        ack = 1'b0;
        rdata = '0;
        wr_count = 0;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
    end

    always @(posedge clk) begin
        if (req && !ack) begin
            ack   <= 1'b1;
            rdata <= mem[addr[11:2]];
            if (we) begin
                mem[addr[11:2]] <= wdata;
                wr_count <= wr_count + 1;
            end
        end else begin
            ack <= 1'b0;
        end
    end
endmodule

module test_dmac_chan;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic        reg_we, l_we;
    logic [5:0]  reg_addr, l_addr;
    logic [31:0] reg_wdata, reg_rdata, l_wdata, l_rdata;
    logic        mem_req, mem_we, mem_ack, l_req, l_mwe, l_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, l_maddr, l_mwdata, l_mrdata;
    logic [3:0]  dreq, l_dreq;
    logic        irq, l_irq;

    int vecs = 0;
    int errs = 0;

    dmac_chan i_dmac_chan (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .dreq(dreq), .irq(irq)
    );
    tb_mem i_mem (
        .clk(clk), .req(mem_req), .we(mem_we), .addr(mem_addr),
        .wdata(mem_wdata), .ack(mem_ack), .rdata(mem_rdata)
    );

    dmac_chan #(.LITE(1'b1)) i_lite (
        .clk(clk), .rst_n(rst_n), .reg_we(l_we), .reg_addr(l_addr),
        .reg_wdata(l_wdata), .reg_rdata(l_rdata), .mem_req(l_req),
        .mem_we(l_mwe), .mem_addr(l_maddr), .mem_wdata(l_mwdata),
        .mem_ack(l_ack), .mem_rdata(l_mrdata), .dreq(l_dreq), .irq(l_irq)
    );
    tb_mem i_lmem (
        .clk(clk), .req(l_req), .we(l_mwe), .addr(l_maddr),
        .wdata(l_mwdata), .ack(l_ack), .rdata(l_mrdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic lwr(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        l_we = 1'b1; l_addr = a; l_wdata = v;
        @(negedge clk);
        l_we = 1'b0;
    endtask

    task automatic lrd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        l_addr = a;
        #1 v = l_rdata;
    endtask

    task automatic put_cb(input int base, input logic [31:0] ti, input logic [31:0] src,
                          input logic [31:0] dst, input logic [31:0] len, input logic [31:0] nxt);
        i_mem.mem[base/4 + 0] = ti;
        i_mem.mem[base/4 + 1] = src;
        i_mem.mem[base/4 + 2] = dst;
        i_mem.mem[base/4 + 3] = len;
        i_mem.mem[base/4 + 4] = 32'h55;
        i_mem.mem[base/4 + 5] = nxt;
    endtask

    task automatic wait_idle(input int lim, output int cyc);
        logic [31:0] v;
        cyc = 0;
        forever begin
            rd(6'h00, v);
            if (!v[0]) break;
            cyc++;
            if (cyc > lim) begin
                chk("R4 channel never returned to idle", v, 32'h0);
                break;
            end
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        logic [31:0] v, l1, l2, ti, lenb, exp;
        int c, c0, c3;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; dreq = '0;
        l_we = 1'b0; l_addr = '0; l_wdata = '0; l_dreq = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(6'h00, v); chk("R1 cs after reset", v, 32'h10);
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        chk("R1 mem_req after reset", {31'b0, mem_req}, 32'h0);
        rd(6'h20, v); chk("R12 debug full variant", v, 32'h0);
        lrd(6'h20, v); chk("R12 debug lite variant", v, 32'h1000_0000);

        // Sweep: lengths 0..6 words x four transfer modes
        for (int n = 0; n <= 6; n++) begin
            for (int mode = 0; mode < 4; mode++) begin
                for (int i = 0; i < 8; i++) begin
                    i_mem.mem[64 + i]  = 32'hA000_0000 + 32'(n * 256 + i);
                    i_mem.mem[128 + i] = 32'hD000_0000 + 32'(i);
                end
                case (mode)
                    0: ti = 32'h0000_0110;
                    1: ti = 32'h0000_0010;
                    2: ti = 32'h0000_0810;
                    default: ti = 32'h0000_0190;
                endcase
                ti[0] = n[0];
                lenb = 32'(4 * n + ((n == 3) ? 2 : 0));
                put_cb(0, ti, 32'h100, 32'h200, lenb, 32'h0);
                wr(6'h04, 32'h0);
                wr(6'h00, 32'h1);
                wait_idle(2000, c);
                for (int i = 0; i < 8; i++) begin
                    if (i >= n || mode == 3) exp = 32'hD000_0000 + 32'(i);
                    else if (mode == 0) exp = 32'hA000_0000 + 32'(n * 256 + i);
                    else if (mode == 1) exp = 32'hA000_0000 + 32'(n * 256);
                    else exp = 32'h0;
                    chk((mode >= 2) ? "R6 ignore dest word" : "R3 copy dest word",
                        i_mem.mem[128 + i], exp);
                end
                rd(6'h00, v);
                chk("R4 end set, run clear", {29'b0, v[2:0] & 3'b011}, 32'h2);
                chk("R4 irq per enable bit", {31'b0, irq}, 32'(n % 2));
                rd(6'h08, v); chk("R2 info readback", v, ti);
                rd(6'h18, v); chk("R2 stride readback", v, 32'h55);
                rd(6'h0C, v);
                chk("R3 source step", v, (mode == 0 || mode == 3) ? 32'h100 + 32'(4 * n) : 32'h100);
                rd(6'h10, v); chk("R3 dest step", v, 32'h200 + 32'(4 * n));
                wr(6'h00, 32'h0);
                rd(6'h00, v); chk("R5 zero write keeps flags", {29'b0, v[2:0]}, {29'b0, n[0], 2'b10});
                wr(6'h00, 32'h6);
                rd(6'h00, v); chk("R5 one clears flags", {29'b0, v[2:0]}, 32'h0);
                chk("R5 irq cleared", {31'b0, irq}, 32'h0);
            end
        end

        // R4 chain of two blocks
        for (int i = 0; i < 4; i++) begin
            i_mem.mem[64 + i] = 32'h1100 + 32'(i);
            i_mem.mem[192 + i] = 32'h3300 + 32'(i);
            i_mem.mem[128 + i] = 32'h0; i_mem.mem[224 + i] = 32'h0;
        end
        put_cb(0, 32'h110, 32'h100, 32'h200, 32'd8, 32'h40);
        put_cb(64, 32'h111, 32'h300, 32'h380, 32'd12, 32'h0);
        wr(6'h04, 32'h0); wr(6'h00, 32'h1);
        wait_idle(2000, c);
        chk("R4 chain block A w1", i_mem.mem[129], 32'h1101);
        chk("R4 chain block A w2 untouched", i_mem.mem[130], 32'h0);
        chk("R4 chain block B w2", i_mem.mem[226], 32'h3302);
        rd(6'h04, v); chk("R4 block address takes link", v, 32'h0);
        chk("R4 irq from block B", {31'b0, irq}, 32'h1);
        wr(6'h00, 32'h6);

        // R8 wait cycles: 4 words with W=0 then W=3
        put_cb(0, 32'h110, 32'h100, 32'h200, 32'd16, 32'h0);
        wr(6'h04, 32'h0); wr(6'h00, 32'h1); wait_idle(2000, c0);
        put_cb(0, 32'h110 | (32'd3 << 21), 32'h100, 32'h200, 32'd16, 32'h0);
        wr(6'h04, 32'h0); wr(6'h00, 32'h1); wait_idle(2000, c3);
        chk("R8 extra cycles for W=3 over 4 words", 32'(c3 - c0), 32'd12);
        wr(6'h00, 32'h6);

        // R7 paced reads on line 2
        for (int i = 0; i < 4; i++) i_mem.mem[128 + i] = 32'h0;
        i_mem.mem[64] = 32'hCAFE_0001;
        put_cb(0, 32'h0000_0410 | (32'd2 << 16), 32'h100, 32'h200, 32'd12, 32'h0);
        wr(6'h04, 32'h0); wr(6'h00, 32'h1);
        dreq = 4'b0010;
        repeat (20) @(negedge clk);
        rd(6'h00, v); chk("R7 held while line low", {31'b0, v[5]}, 32'h1);
        rd(6'h14, v); chk("R7 no word moved while held", v, 32'd12);
        chk("R7 dest untouched while held", i_mem.mem[128], 32'h0);
        dreq = 4'b0100;
        wait_idle(2000, c);
        chk("R7 paced dest w2", i_mem.mem[130], 32'hCAFE_0001);
        rd(6'h00, v); chk("R7 held clear when done", {31'b0, v[5]}, 32'h0);
        dreq = 4'b0000;

        // R9 pause and resume on a 40-word copy
        for (int i = 0; i < 40; i++) begin
            i_mem.mem[256 + i] = 32'h9000 + 32'(i);
            i_mem.mem[512 + i] = 32'h0;
        end
        put_cb(0, 32'h110, 32'h400, 32'h800, 32'd160, 32'h0);
        wr(6'h04, 32'h0); wr(6'h00, 32'h1);
        repeat (30) @(negedge clk);
        wr(6'h00, 32'h0);
        repeat (5) @(negedge clk);
        rd(6'h14, l1);
        repeat (20) @(negedge clk);
        rd(6'h14, l2);
        chk("R9 remaining length frozen while paused", l2, l1);
        rd(6'h00, v); chk("R9 paused bit", {31'b0, v[4]}, 32'h1);
        chk("R9 no request while paused", {31'b0, mem_req}, 32'h0);
        wr(6'h04, 32'h3C0);
        rd(6'h04, v); chk("R2 block address ignored while busy", v, 32'h0);
        wr(6'h00, 32'h1);
        wait_idle(2000, c);
        chk("R9 resumed copy last word", i_mem.mem[551], 32'h9027);
        wr(6'h00, 32'h6);

        // R10 abort long block, chain continues
        for (int i = 0; i < 200; i++) begin
            i_mem.mem[256 + i] = 32'h7000 + 32'(i);
            i_mem.mem[512 + i] = 32'h0;
        end
        i_mem.mem[64] = 32'hB0B0_0000; i_mem.mem[65] = 32'hB0B0_0001;
        i_mem.mem[192] = 32'h0; i_mem.mem[193] = 32'h0;
        put_cb(0, 32'h110, 32'h400, 32'h800, 32'd800, 32'h40);
        put_cb(64, 32'h110, 32'h100, 32'h300, 32'd8, 32'h0);
        wr(6'h04, 32'h0); wr(6'h00, 32'h1);
        repeat (40) @(negedge clk);
        wr(6'h00, 32'h4000_0001);
        wait_idle(4000, c);
        chk("R10 aborted block tail unwritten", i_mem.mem[711], 32'h0);
        chk("R10 next block copied", i_mem.mem[193], 32'hB0B0_0001);
        rd(6'h00, v); chk("R10 end flag", {31'b0, v[1]}, 32'h1);
        wr(6'h00, 32'h6);

        // R11 reset command mid-transfer
        put_cb(0, 32'h111, 32'h400, 32'h800, 32'd800, 32'h0);
        wr(6'h04, 32'h0); wr(6'h00, 32'h1);
        repeat (30) @(negedge clk);
        wr(6'h00, 32'h8000_0000);
        rd(6'h00, v); chk("R11 cs after reset command", v, 32'h10);
        repeat (5) @(negedge clk);
        chk("R11 no request after reset command", {31'b0, mem_req}, 32'h0);
        chk("R11 irq low", {31'b0, irq}, 32'h0);

        // R12 lite cap: 64 KiB requested, zero reads, fixed destination
        i_lmem.mem[0] = 32'h0000_0800;
        i_lmem.mem[1] = 32'h0;
        i_lmem.mem[2] = 32'h3F0;
        i_lmem.mem[3] = 32'h0001_0000;
        i_lmem.mem[5] = 32'h0;
        lwr(6'h04, 32'h0); lwr(6'h00, 32'h1);
        begin
            int lc;
            lc = 0;
            forever begin
                lrd(6'h00, v);
                if (!v[0]) break;
                lc++;
                if (lc > 120000) begin
                    chk("R12 lite never finished", v, 32'h0);
                    break;
                end
            end
        end
        chk("R12 lite capped write count", 32'(i_lmem.wr_count), 32'd16383);
        lrd(6'h14, v); chk("R12 lite remaining length", v, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule